// File: doc/BRIEF.md
# Subcarrier Load-Modulation Frame Transmitter

This block sends the card-side answer of a contactless link. It drives a modulation enable that switches a subcarrier on for a 1 and off for a 0. Each bit owns a fixed slot of 21 ticks. The first slot does not start when the request arrives. It starts a fixed number of ticks after the end of the last reader frame. That end is taken from a timestamp shared with the receive decoder. A normal data frame starts 70 ticks later. A write acknowledge starts 758 ticks later.

Data frames go out least significant bit first. Each bit is XORed with a keystream bit. The block pulses a keystream advance strobe once per transmitted bit. During the wait it also issues extra advances so that the keystream source stays aligned with the tick slots that pass. An acknowledge is a single unscrambled 1. When the last slot ends, the block drops modulation, pulses done, and returns the updated shared timestamp for the next exchange. The free-running tick timebase `now_ts` comes from outside, as does the subcarrier waveform itself.

Top module: `sc_frame_tx`

## Requirements
- R1: After reset, `mod_en`, `ks_adv` and `done` are 0 and `frame_end_next` is 0.
- R2: With `mode_ack`=0 at `start`, the first bit slot begins when `now_ts` reaches `frame_end_ts`+70. `mod_en` is 0 before that and shows bit 0 from the following clock.
- R3: With `mode_ack`=1 at `start`, the single acknowledge slot begins when `now_ts` reaches `frame_end_ts`+758, and `mod_en` is 0 before that.
- R4: In a data frame, slot i (i = 0 .. `tx_len`-1) carries `tx_data[i]` XOR the `ks_bit` value present when that slot begins, and each slot lasts 21 ticks.
- R5: An acknowledge frame carries one slot with `mod_en`=1 regardless of `ks_bit` and `tx_data`.
- R6: Per frame, `ks_adv` pulses 2 times (data) or 35 times (acknowledge) before the first slot, plus once per transmitted bit, each pulse one clock wide.
- R7: `mod_en` stays constant for the whole slot, including across equal neighbouring bits, and is 0 once the last slot ends and whenever the block is idle.
- R8: `done` is high for exactly one clock when the last slot ends. At that point `frame_end_next` equals the slot start time plus 21 times the number of bits.
- R9: A `start` seen while a frame is waiting or being sent, including in the clock where the last slot ends, has no effect. No new frame, modulation or advance follows it.
- R10: A data frame with `tx_len`=0 sends no slot. It still issues the 2 wait advances, and pulses `done` when `now_ts` reaches `frame_end_ts`+70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ts | input | 20 | Free-running tick timebase |
| frame_end_ts | input | 20 | Tick stamp of the last reader frame end, sampled at start |
| start | input | 1 | One-clock request to transmit |
| mode_ack | input | 1 | 1: write acknowledge, 0: scrambled data frame |
| tx_data | input | 16 | Frame bits, bit 0 sent first |
| tx_len | input | 5 | Number of data bits, 0 to 16 |
| ks_bit | input | 1 | Current keystream bit |
| mod_en | output | 1 | Subcarrier modulation enable |
| ks_adv | output | 1 | Keystream advance strobe |
| done | output | 1 | One-clock pulse at the end of the frame |
| frame_end_next | output | 20 | Updated shared timestamp after the frame |

## Verification
The delicate coincidence is the end of the last slot and a new start request landing in the same clock. The controller retires the frame and accepts requests on adjacent edges. The bench therefore raises `start` exactly as `now_ts` steps onto the final slot boundary. It then expects one `done` pulse, no further `ks_adv` pulses and a silent `mod_en` for many slots afterwards. A second provocation drops a start into the middle of a running frame. The scoreboard's per-slot modulation values must come out unchanged.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WAIT = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        FRM_DATA = 1'b0,
        FRM_ACK  = 1'b1
    } frm_kind_e;

    // Whole slots that elapse during a wait, minus the one the first bit consumes
    function automatic int pre_advances(input int gap_ticks, input int slot_ticks);
        return gap_ticks / slot_ticks - 1;
    endfunction

endpackage

// File: rtl/txf_deadline.sv
module txf_deadline #(
    parameter int TS_W   = 20,
    parameter int PERIOD = 21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    input  logic            bump,
    input  logic [TS_W-1:0] now_ts,
    output logic [TS_W-1:0] target,
    output logic            reached
);
    logic [TS_W-1:0] diff;

    // wrap-safe "now is at or past target"
    assign diff    = now_ts - target;
    assign reached = ~diff[TS_W-1];

    always_ff @(posedge clk) begin
        if (rst)       target <= '0;
        else if (load) target <= load_val;
        else if (bump) target <= target + TS_W'(PERIOD);
    end
endmodule

// File: rtl/txf_adv_pace.sv
module txf_adv_pace #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt;

    assign pulse = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (load)  cnt <= load_cnt;
        else if (pulse) cnt <= cnt - CNT_W'(1);
    end

    AST_PACE_SETTLED: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !load) |=> !pulse); // R6
endmodule

// File: rtl/txf_bitsel.sv
module txf_bitsel
    import sc_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  frm_kind_e         kind,
    input  logic [DATA_W-1:0] bits,
    input  logic [IDX_W-1:0]  idx,
    input  logic              ks_bit,
    output logic              tx_bit
);
    always_comb begin
        if (kind == FRM_ACK) tx_bit = 1'b1;
        else                 tx_bit = bits[idx] ^ ks_bit;
    end
endmodule

// File: rtl/sc_frame_tx.sv
module sc_frame_tx
    import sc_tx_pkg::*;
#(
    parameter int TS_W      = 20,
    parameter int DATA_W    = 16,
    parameter int BIT_TICKS = 21,
    parameter int DATA_GAP  = 70,
    parameter int ACK_GAP   = 758
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [TS_W-1:0]             now_ts,
    input  logic [TS_W-1:0]             frame_end_ts,
    input  logic                        start,
    input  logic                        mode_ack,
    input  logic [DATA_W-1:0]           tx_data,
    input  logic [$clog2(DATA_W+1)-1:0] tx_len,
    input  logic                        ks_bit,
    output logic                        mod_en,
    output logic                        ks_adv,
    output logic                        done,
    output logic [TS_W-1:0]             frame_end_next
);
    localparam int LEN_W    = $clog2(DATA_W + 1);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int DATA_PRE = pre_advances(DATA_GAP, BIT_TICKS);
    localparam int ACK_PRE  = pre_advances(ACK_GAP, BIT_TICKS);
    localparam int ADV_W    = $clog2(ACK_PRE + 1);

    tx_state_e         st_q;
    frm_kind_e         kind_q;
    logic [DATA_W-1:0] bits_q;
    logic [LEN_W-1:0]  nbits_q;
    logic [LEN_W-1:0]  idx_q;
    logic              mod_q, bit_adv_q, done_q;
    logic [TS_W-1:0]   fe_next_q;

    logic              accept, reached, pace_pulse, tx_bit, last_slot;
    logic              first_go, next_go, bump;
    logic [TS_W-1:0]   target;
    logic [LEN_W-1:0]  sel_idx;

    assign accept    = (st_q == TX_IDLE) && start;
    assign last_slot = (idx_q + LEN_W'(1)) == nbits_q;
    assign first_go  = (st_q == TX_WAIT) && reached && !pace_pulse && (nbits_q != '0);
    assign next_go   = (st_q == TX_SEND) && reached && !last_slot;
    assign bump      = first_go || next_go;
    assign sel_idx   = (st_q == TX_SEND) ? idx_q + LEN_W'(1) : '0;

    txf_deadline #(.TS_W(TS_W), .PERIOD(BIT_TICKS)) u_deadline (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (frame_end_ts + (mode_ack ? TS_W'(ACK_GAP) : TS_W'(DATA_GAP))),
        .bump     (bump),
        .now_ts   (now_ts),
        .target   (target),
        .reached  (reached)
    );

    txf_adv_pace #(.CNT_W(ADV_W)) u_pace (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_cnt (mode_ack ? ADV_W'(ACK_PRE) : ADV_W'(DATA_PRE)),
        .pulse    (pace_pulse)
    );

    txf_bitsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitsel (
        .kind   (kind_q),
        .bits   (bits_q),
        .idx    (sel_idx[IDX_W-1:0]),
        .ks_bit (ks_bit),
        .tx_bit (tx_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= TX_IDLE;
            kind_q    <= FRM_DATA;
            bits_q    <= '0;
            nbits_q   <= '0;
            idx_q     <= '0;
            mod_q     <= 1'b0;
            bit_adv_q <= 1'b0;
            done_q    <= 1'b0;
            fe_next_q <= '0;
        end else begin
            bit_adv_q <= 1'b0;
            done_q    <= 1'b0;
            unique case (st_q)
                TX_IDLE: if (start) begin
                    kind_q  <= mode_ack ? FRM_ACK : FRM_DATA;
                    bits_q  <= tx_data;
                    nbits_q <= mode_ack ? LEN_W'(1) : tx_len;
                    idx_q   <= '0;
                    st_q    <= TX_WAIT;
                end
                TX_WAIT: if (reached && !pace_pulse) begin
                    if (nbits_q == '0) begin
                        done_q    <= 1'b1;
                        fe_next_q <= target;
                        st_q      <= TX_IDLE;
                    end else begin
                        mod_q     <= tx_bit;
                        bit_adv_q <= 1'b1;
                        st_q      <= TX_SEND;
                    end
                end
                TX_SEND: if (reached) begin
                    if (last_slot) begin
                        mod_q     <= 1'b0;
                        done_q    <= 1'b1;
                        fe_next_q <= target;
                        st_q      <= TX_IDLE;
                    end else begin
                        mod_q     <= tx_bit;
                        bit_adv_q <= 1'b1;
                        idx_q     <= idx_q + LEN_W'(1);
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign mod_en         = mod_q;
    assign ks_adv         = pace_pulse | bit_adv_q;
    assign done           = done_q;
    assign frame_end_next = fe_next_q;

    AST_ADV_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(pace_pulse && bit_adv_q)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == TX_IDLE) |-> !mod_q); // R7
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == TX_SEND && !reached) |=> $stable(mod_q)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (st_q != TX_IDLE && start) |=> ($stable(bits_q) && $stable(kind_q))); // R9
endmodule

// File: tb/sc_frame_tx_tb_top.sv
module sc_frame_tx_tb_top;
    localparam int TS_W = 20;
    localparam int DW   = 16;
    localparam int LW   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TS_W-1:0] now_ts = '0;
    logic [TS_W-1:0] frame_end_ts = '0;
    logic          start = 1'b0;
    logic          mode_ack = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [LW-1:0] tx_len = '0;
    logic          ks_bit;
    logic          mod_en, ks_adv, done;
    logic [TS_W-1:0] frame_end_next;

    logic [6:0] lfsr = 7'h1D;
    int unsigned ks_cnt = 0;
    int unsigned done_cnt = 0;
    int unsigned phase = 0;
    int unsigned cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit wd = 1'b0;

    typedef struct {
        int unsigned ts;
        logic        val;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    assign ks_bit = lfsr[0];

    sc_frame_tx dut_i (
        .clk(clk), .rst(rst), .now_ts(now_ts), .frame_end_ts(frame_end_ts),
        .start(start), .mode_ack(mode_ack), .tx_data(tx_data), .tx_len(tx_len),
        .ks_bit(ks_bit), .mod_en(mod_en), .ks_adv(ks_adv), .done(done),
        .frame_end_next(frame_end_next)
    );

    function automatic logic [6:0] lfsr_step(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    function automatic logic ks_after(input logic [6:0] s, input int k);
        logic [6:0] t = s;
        for (int j = 0; j < k; j++) t = lfsr_step(t);
        return t[0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // keystream model and event counters
    always @(posedge clk) begin
        if (ks_adv) begin
            lfsr   <= lfsr_step(lfsr);
            ks_cnt <= ks_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    // tick timebase and scoreboard monitor
    always @(negedge clk) begin
        if (phase == 1 && sb.size() != 0 && int'(now_ts) == sb[0].ts) begin
            check(mod_en === sb[0].val, sb[0].req, mod_en, sb[0].val);
            void'(sb.pop_front());
        end
        phase <= (phase + 1) % 4;
        if (phase == 3) now_ts <= now_ts + 1'b1;
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !wd) begin
            wd = 1'b1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send(input bit ack, input logic [DW-1:0] d, input int len);
        int unsigned fe, w, pre, n, ks0, dc0;
        logic [6:0] s0;
        string rq;
        @(negedge clk);
        fe  = now_ts;
        s0  = lfsr;
        ks0 = ks_cnt;
        dc0 = done_cnt;
        w   = ack ? 758 : 70;
        pre = ack ? 35 : 2;
        n   = ack ? 1 : len;
        rq  = ack ? "R3" : "R2";
        frame_end_ts = fe;
        mode_ack = ack;
        tx_data  = d;
        tx_len   = LW'(len);
        start    = 1'b1;
        sb.push_back('{fe + w - 1, 1'b0, rq});
        if (n != 0)
            sb.push_back('{fe + w + 1, ack ? 1'b1 : logic'(d[0] ^ ks_after(s0, pre)), rq});
        for (int i = 0; i < n; i++)
            sb.push_back('{fe + w + 21*i + 10,
                           ack ? 1'b1 : logic'(d[i] ^ ks_after(s0, pre + i)),
                           ack ? "R5" : "R4"});
        sb.push_back('{fe + w + 21*n + 2, 1'b0, "R7"});
        @(negedge clk);
        start = 1'b0;
        while (!done && !wd) @(negedge clk);
        if (n == 0) begin
            check(int'(now_ts) == fe + w, "R10 done time", now_ts, fe + w);
            check(ks_cnt - ks0 == pre, "R10 advances", ks_cnt - ks0, pre);
        end else begin
            check(int'(now_ts) == fe + w + 21*n, "R8 done time", now_ts, fe + w + 21*n);
            check(ks_cnt - ks0 == pre + n, "R6 advances", ks_cnt - ks0, pre + n);
        end
        check(int'(frame_end_next) == fe + w + 21*n, "R8 frame_end_next",
              frame_end_next, fe + w + 21*n);
        repeat (20) @(negedge clk);
        check(done_cnt - dc0 == 1, "R8 single done", done_cnt - dc0, 1);
        while (sb.size() != 0 && !wd) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mod_en === 1'b0, "R1 mod_en", mod_en, 0);
        check(ks_adv === 1'b0, "R1 ks_adv", ks_adv, 0);
        check(done === 1'b0, "R1 done", done, 0);
        check(frame_end_next === '0, "R1 frame_end_next", frame_end_next, 0);
        rst = 1'b0;
        repeat (8) @(negedge clk);

        send(1'b0, 16'h0A5C, 12);          // R2 R4 mixed pattern
        send(1'b0, 16'hFFFF, 16);          // R4 R7 full length, all ones
        send(1'b0, 16'h0000, 16);          // R4 all zeros
        send(1'b1, 16'h0000, 0);           // R3 R5 acknowledge
        send(1'b0, 16'h0001, 1);           // R4 single bit
        send(1'b0, 16'h0000, 0);           // R10 empty frame

        // R9: start in the middle of a running frame
        fork
            send(1'b0, 16'h00C3, 8);
            begin
                while (int'(now_ts) != int'(frame_end_ts) + 70 + 30 && !wd) @(negedge clk);
                mode_ack = 1'b1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join

        // R9: start in the same clock as the last slot ends
        begin
            int unsigned ks1, dc1, tend;
            fork
                send(1'b0, 16'h0096, 4);
                begin
                    @(negedge clk);
                    @(negedge clk);
                    tend = int'(frame_end_ts) + 70 + 21*4;
                    while (!(phase == 3 && int'(now_ts) == tend - 1) && !wd) @(negedge clk);
                    mode_ack = 1'b0; tx_len = 5'd3; start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            join
            ks1 = ks_cnt;
            dc1 = done_cnt;
            repeat (4 * 800) begin
                @(negedge clk);
                if (mod_en !== 1'b0) break;
            end
            check(mod_en === 1'b0, "R9 no modulation after ignored start", mod_en, 0);
            check(ks_cnt == ks1, "R9 no advances after ignored start", ks_cnt, ks1);
            check(done_cnt == dc1, "R9 no done after ignored start", done_cnt, dc1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule